// File: doc/BRIEF.md
# Coprocessor Instruction Offload Unit

This unit is an execute-stage functional unit. It receives instructions that the core's decoder could not decode and offers them to an external coprocessor. Each instruction is treated as a three-source-operand format, so the instruction word travels with three operand values and a transaction ID. The coprocessor answers over three handshakes. On the issue channel it takes the offer and says in the same cycle whether it accepts the instruction. On the commit channel the unit confirms or kills the accepted instruction. On the result channel the coprocessor returns the writeback value.

Every offloaded instruction that is not flushed produces exactly one entry on the single writeback port. That entry is the coprocessor's result when the instruction was accepted. It is an illegal-instruction exception when the instruction was refused. Only one offload is in flight at a time, so every result belongs to the pending transaction. A compile-time parameter removes the coprocessor path. With it removed, every undecodable instruction raises the exception directly.

Top module: `cpx_offload_unit`

## Requirements
- R1: After reset, the unit has no offload pending. No commit is offered, `xr_ready_o` and `wb_valid_o` are low, and `op_ready_o` follows `xi_ready_i`.
- R2: When idle and `flush_i` is low, `xi_valid_o` equals `op_valid_i` and `op_ready_o` equals `xi_ready_i`. The instruction word, the three operands and the ID are forwarded unchanged.
- R3: An issue handshake with `xi_accept_i` low gives, in that same cycle, a writeback entry with `wb_exc_valid_o` high and `wb_exc_cause_o` equal to the parameter `ILL_CAUSE` (default 2). `wb_data_o` carries the instruction word, zero-extended. `wb_id_o` is the offered ID and `wb_we_o` is low.
- R4: An issue handshake with `xi_accept_i` high is followed, in the next cycle, by `xc_valid_o` high for one cycle. `xc_id_o` is the accepted ID.
- R5: From the cycle after an accepted issue until the cycle after its result handshake or kill, `xi_valid_o` and `op_ready_o` stay low.
- R6: `xr_ready_o` is high only in the cycles after the commit that wait for the result. A result handshake there gives a writeback in the same cycle. That writeback carries the stored ID, `xr_data_i` and `xr_rd_i`, with `wb_we_o` = `xr_we_i` AND the writeback flag sampled at issue.
- R7: A flush in the commit cycle sets `xc_kill_o` high. No writeback follows for that instruction, and the unit is idle in the next cycle.
- R8: A flush while the unit waits for a result makes that result be taken without any writeback. The unit is then idle.
- R9: In a cycle with `flush_i` high, no issue handshake can occur: `xi_valid_o` and `op_ready_o` are low.
- R10: `wb_exc_valid_o` and `wb_we_o` are never high together.
- R11: With `ENABLE` = 0, `op_ready_o` is always high and `xi_valid_o` always low. Each `op_valid_i` without flush gives the R3 exception entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard pending offload, block issue |
| op_valid_i | input | 1 | Undecodable instruction offered by the core |
| op_ready_o | output | 1 | Unit takes the instruction this cycle |
| op_instr_i | input | 32 | Instruction word |
| op_rs1_i | input | XLEN | First source operand |
| op_rs2_i | input | XLEN | Second source operand |
| op_rs3_i | input | XLEN | Third source operand |
| op_id_i | input | ID_W | Transaction ID |
| xi_valid_o | output | 1 | Issue request valid |
| xi_ready_i | input | 1 | Coprocessor takes issue request |
| xi_instr_o | output | 32 | Issued instruction word |
| xi_rs1_o | output | XLEN | Issued operand 1 |
| xi_rs2_o | output | XLEN | Issued operand 2 |
| xi_rs3_o | output | XLEN | Issued operand 3 |
| xi_id_o | output | ID_W | Issued ID |
| xi_accept_i | input | 1 | Coprocessor accepts instruction |
| xi_writeback_i | input | 1 | Accepted instruction will write a register |
| xc_valid_o | output | 1 | Commit valid |
| xc_id_o | output | ID_W | Commit ID |
| xc_kill_o | output | 1 | Commit kills the instruction |
| xr_valid_i | input | 1 | Result valid |
| xr_ready_o | output | 1 | Unit takes result |
| xr_id_i | input | ID_W | Result ID |
| xr_data_i | input | XLEN | Result data |
| xr_rd_i | input | 5 | Destination register index |
| xr_we_i | input | 1 | Result writes a register |
| wb_valid_o | output | 1 | Writeback entry valid |
| wb_id_o | output | ID_W | Writeback ID |
| wb_data_o | output | XLEN | Result data or instruction word |
| wb_rd_o | output | 5 | Destination register |
| wb_we_o | output | 1 | Register write enable |
| wb_exc_valid_o | output | 1 | Illegal-instruction exception |
| wb_exc_cause_o | output | 6 | Exception cause code |

## Verification
A wrong pending state shows at the ports within one cycle. It appears as a lost or extra commit, as `xr_ready_o` asserted outside the wait window, or as a new issue accepted while a result is still owed. A wrong stored ID, writeback flag or drop flag shows only when the result arrives. It then appears as a writeback with the wrong ID or enable, or as a writeback that should have been suppressed after a flush. The bench therefore drives random result delays and flushes in every phase, and compares every output on every clock.

// File: rtl/cpx_offload_unit.sv
module cpx_offload_unit #(
  parameter int XLEN      = 32,
  parameter int ID_W      = 3,
  parameter bit ENABLE    = 1'b1,
  parameter int ILL_CAUSE = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            op_valid_i,
  output logic            op_ready_o,
  input  logic [31:0]     op_instr_i,
  input  logic [XLEN-1:0] op_rs1_i,
  input  logic [XLEN-1:0] op_rs2_i,
  input  logic [XLEN-1:0] op_rs3_i,
  input  logic [ID_W-1:0] op_id_i,
  output logic            xi_valid_o,
  input  logic            xi_ready_i,
  output logic [31:0]     xi_instr_o,
  output logic [XLEN-1:0] xi_rs1_o,
  output logic [XLEN-1:0] xi_rs2_o,
  output logic [XLEN-1:0] xi_rs3_o,
  output logic [ID_W-1:0] xi_id_o,
  input  logic            xi_accept_i,
  input  logic            xi_writeback_i,
  output logic            xc_valid_o,
  output logic [ID_W-1:0] xc_id_o,
  output logic            xc_kill_o,
  input  logic            xr_valid_i,
  output logic            xr_ready_o,
  input  logic [ID_W-1:0] xr_id_i,
  input  logic [XLEN-1:0] xr_data_i,
  input  logic [4:0]      xr_rd_i,
  input  logic            xr_we_i,
  output logic            wb_valid_o,
  output logic [ID_W-1:0] wb_id_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic [4:0]      wb_rd_o,
  output logic            wb_we_o,
  output logic            wb_exc_valid_o,
  output logic [5:0]      wb_exc_cause_o
);

  typedef enum logic [1:0] {S_IDLE, S_CMT, S_WAIT} st_e;

  st_e            st_q;
  logic [ID_W-1:0] id_q;
  logic            wbf_q, drop_q;

  logic idle, iss_fire, reject, res_fire, res_wb, exc;

  assign idle       = (st_q == S_IDLE);
  assign xi_valid_o = ENABLE && idle && op_valid_i && !flush_i;
  assign op_ready_o = ENABLE ? (idle && xi_ready_i && !flush_i) : 1'b1;
  assign xi_instr_o = op_instr_i;
  assign xi_rs1_o   = op_rs1_i;
  assign xi_rs2_o   = op_rs2_i;
  assign xi_rs3_o   = op_rs3_i;
  assign xi_id_o    = op_id_i;

  assign iss_fire = xi_valid_o && xi_ready_i;
  assign reject   = iss_fire && !xi_accept_i;

  assign xc_valid_o = (st_q == S_CMT);
  assign xc_id_o    = id_q;
  assign xc_kill_o  = xc_valid_o && flush_i;

  assign xr_ready_o = (st_q == S_WAIT);
  assign res_fire   = xr_valid_i && xr_ready_o;
  assign res_wb     = res_fire && !drop_q && !flush_i;

  assign exc = reject || (!ENABLE && op_valid_i && !flush_i);

  assign wb_valid_o     = exc || res_wb;
  assign wb_id_o        = exc ? op_id_i : id_q;
  assign wb_data_o      = exc ? XLEN'(op_instr_i) : xr_data_i;
  assign wb_rd_o        = res_wb ? xr_rd_i : 5'd0;
  assign wb_we_o        = res_wb && xr_we_i && wbf_q;
  assign wb_exc_valid_o = exc;
  assign wb_exc_cause_o = exc ? 6'(ILL_CAUSE) : 6'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      id_q   <= '0;
      wbf_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (iss_fire && xi_accept_i) begin
          st_q   <= S_CMT;
          id_q   <= op_id_i;
          wbf_q  <= xi_writeback_i;
          drop_q <= 1'b0;
        end
        S_CMT: st_q <= flush_i ? S_IDLE : S_WAIT;
        S_WAIT: begin
          if (flush_i) drop_q <= 1'b1;
          if (res_fire) begin
            st_q   <= S_IDLE;
            drop_q <= 1'b0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  AST_EXC_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wb_exc_valid_o && wb_we_o)); // R10
  AST_REJECT_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xi_valid_o && xi_ready_i && !xi_accept_i) |-> (wb_valid_o && wb_exc_valid_o)); // R3
  AST_COMMIT_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xi_valid_o && xi_ready_i && xi_accept_i) |=> (xc_valid_o && xc_id_o == $past(op_id_i))); // R4
  AST_NO_ISSUE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xc_valid_o || xr_ready_o) |-> (!xi_valid_o && (!op_ready_o || !ENABLE))); // R5
  AST_KILL_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xc_valid_o && xc_kill_o) |=> (!xr_ready_o && !xc_valid_o)); // R7
  AST_RESULT_AFTER_CMT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xr_ready_o) |-> $past(xc_valid_o && !xc_kill_o)); // R6
  AST_RESULT_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xr_valid_i && xr_ready_o && wb_valid_o) |-> (wb_id_o == xr_id_i)); // R6
  AST_FLUSH_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !xi_valid_o); // R9

endmodule

// File: tb/sim_cpx_offload_unit.sv
module sim_cpx_offload_unit;
  localparam int XLEN = 32, ID_W = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic            fl, opv, xrdy, acc, wbf, xrv, xwe;
  logic [31:0]     instr;
  logic [XLEN-1:0] r1, r2, r3, xdata;
  logic [ID_W-1:0] opid, xrid;
  logic [4:0]      xrd;

  logic            opr0, xiv0, xcv0, xck0, xrr0, wbv0, wbwe0, wbe0;
  logic [31:0]     xii0;
  logic [XLEN-1:0] xa0, xb0, xc0, wbd0;
  logic [ID_W-1:0] xid0, xcid0, wbid0;
  logic [4:0]      wbrd0;
  logic [5:0]      wbc0;

  logic            opr1, xiv1, xcv1, xck1, xrr1, wbv1, wbwe1, wbe1;
  logic [31:0]     xii1;
  logic [XLEN-1:0] xa1, xb1, xc1, wbd1;
  logic [ID_W-1:0] xid1, xcid1, wbid1;
  logic [4:0]      wbrd1;
  logic [5:0]      wbc1;

  cpx_offload_unit #(.XLEN(XLEN), .ID_W(ID_W), .ENABLE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(fl), .op_valid_i(opv), .op_ready_o(opr0),
    .op_instr_i(instr), .op_rs1_i(r1), .op_rs2_i(r2), .op_rs3_i(r3), .op_id_i(opid),
    .xi_valid_o(xiv0), .xi_ready_i(xrdy), .xi_instr_o(xii0), .xi_rs1_o(xa0), .xi_rs2_o(xb0),
    .xi_rs3_o(xc0), .xi_id_o(xid0), .xi_accept_i(acc), .xi_writeback_i(wbf),
    .xc_valid_o(xcv0), .xc_id_o(xcid0), .xc_kill_o(xck0),
    .xr_valid_i(xrv), .xr_ready_o(xrr0), .xr_id_i(xrid), .xr_data_i(xdata), .xr_rd_i(xrd),
    .xr_we_i(xwe), .wb_valid_o(wbv0), .wb_id_o(wbid0), .wb_data_o(wbd0), .wb_rd_o(wbrd0),
    .wb_we_o(wbwe0), .wb_exc_valid_o(wbe0), .wb_exc_cause_o(wbc0));

  cpx_offload_unit #(.XLEN(XLEN), .ID_W(ID_W), .ENABLE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(fl), .op_valid_i(opv), .op_ready_o(opr1),
    .op_instr_i(instr), .op_rs1_i(r1), .op_rs2_i(r2), .op_rs3_i(r3), .op_id_i(opid),
    .xi_valid_o(xiv1), .xi_ready_i(xrdy), .xi_instr_o(xii1), .xi_rs1_o(xa1), .xi_rs2_o(xb1),
    .xi_rs3_o(xc1), .xi_id_o(xid1), .xi_accept_i(acc), .xi_writeback_i(wbf),
    .xc_valid_o(xcv1), .xc_id_o(xcid1), .xc_kill_o(xck1),
    .xr_valid_i(xrv), .xr_ready_o(xrr1), .xr_id_i(xrid), .xr_data_i(xdata), .xr_rd_i(xrd),
    .xr_we_i(xwe), .wb_valid_o(wbv1), .wb_id_o(wbid1), .wb_data_o(wbd1), .wb_rd_o(wbrd1),
    .wb_we_o(wbwe1), .wb_exc_valid_o(wbe1), .wb_exc_cause_o(wbc1));

  int checks = 0, fails = 0;
  int phase = 0;
  logic [ID_W-1:0] m_id;
  logic m_wbf, m_drop;
  bit done = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit idle, fire, rfire, ewbv, eexc, eres;
    idle  = (phase == 0);
    fire  = idle && opv && !fl && xrdy;
    rfire = (phase == 2) && xrv;
    eexc  = fire && !acc;
    eres  = rfire && !m_drop && !fl;
    ewbv  = eexc || eres;
    chk(fl ? "R9 issue valid" : (idle ? "R2 issue valid" : "R5 issue valid"), xiv0, idle && opv && !fl);
    chk(fl ? "R9 op ready" : (idle ? "R2 op ready" : "R5 op ready"), opr0, idle && xrdy && !fl);
    if (xiv0) begin
      chk("R2 instr", xii0, instr);
      chk("R2 operands", {xa0 ^ xb0 ^ xc0, xid0}, {r1 ^ r2 ^ r3, opid});
    end
    chk("R4 commit valid", xcv0, phase == 1);
    if (phase == 1) begin
      chk("R4 commit id", xcid0, m_id);
      chk("R7 kill", xck0, fl);
    end
    chk("R6 result ready", xrr0, phase == 2);
    chk(m_drop || fl ? "R8 writeback valid" : "R6 writeback valid", wbv0, ewbv);
    chk("R10 exc with write", wbe0 && wbwe0, 0);
    if (eexc) begin
      chk("R3 exc", wbe0, 1);
      chk("R3 cause", wbc0, 2);
      chk("R3 data", wbd0, instr);
      chk("R3 id", wbid0, opid);
      chk("R3 we", wbwe0, 0);
    end
    if (eres) begin
      chk("R6 exc", wbe0, 0);
      chk("R6 id", wbid0, m_id);
      chk("R6 data", wbd0, xdata);
      chk("R6 rd", wbrd0, xrd);
      chk("R6 we", wbwe0, xwe && m_wbf);
    end
    chk("R11 ready", opr1, 1);
    chk("R11 issue", xiv1, 0);
    chk("R11 wb valid", wbv1, opv && !fl);
    if (opv && !fl) begin
      chk("R11 exc", {wbe1, wbc1, wbwe1}, {1'b1, 6'd2, 1'b0});
      chk("R11 id data", {wbid1, wbd1}, {opid, instr});
    end
  endtask

  task automatic advance();
    bit fire;
    fire = (phase == 0) && opv && !fl && xrdy;
    @(posedge clk);
    case (phase)
      0: if (fire && acc) begin phase = 1; m_id = opid; m_wbf = wbf; m_drop = 0; end
      1: phase = fl ? 0 : 2;
      default: begin
        if (fl) m_drop = 1;
        if (xrv) begin phase = 0; m_drop = 0; end
      end
    endcase
  endtask

  task automatic drive(input int flush_odds);
    @(negedge clk);
    fl    = ($urandom_range(flush_odds - 1) == 0);
    opv   = $urandom_range(1);
    xrdy  = $urandom_range(3) != 0;
    acc   = $urandom_range(2) != 0;
    wbf   = $urandom_range(3) != 0;
    xrv   = $urandom_range(2) == 0;
    xwe   = $urandom_range(1);
    instr = $urandom;
    r1 = $urandom; r2 = $urandom; r3 = $urandom;
    opid  = ID_W'($urandom);
    xdata = $urandom;
    xrd   = 5'($urandom);
    xrid  = m_id;
    #1;
  endtask

  initial begin
    fl = 0; opv = 0; xrdy = 1; acc = 0; wbf = 0; xrv = 0; xwe = 0;
    instr = 0; r1 = 0; r2 = 0; r3 = 0; opid = 0; xdata = 0; xrd = 0; xrid = 0;
    m_id = 0; m_wbf = 0; m_drop = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R1 commit", xcv0, 0);
    chk("R1 result ready", xrr0, 0);
    chk("R1 wb", wbv0, 0);
    chk("R1 op ready", opr0, 1);
    for (int i = 0; i < 1500; i++) begin drive(16); compare(); advance(); end
    for (int i = 0; i < 1500; i++) begin drive(3);  compare(); advance(); end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); fails++; checks++;
        $display("FAIL watchdog expired"); end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule